// File: doc/BRIEF.md
# Programmable Decimating CIC Filter

This block reduces the sample rate of a complex (I/Q) stream with a cascaded integrator-comb filter. Each accepted input sample first passes through a power-of-two gain stage. That gain can attenuate hard enough to cancel the very large gain of a long, high-order CIC. The scaled sample then enters a chain of up to five integrators. Once every R accepted samples, the integrator result is differenced through a matching chain of combs, rounded, saturated, and presented with a one-cycle valid strobe.

The filter order, the decimation factor, the gain code and a bypass flag are plain configuration inputs, and they may be changed at run time. Out-of-range settings are clamped to the nearest legal value. The largest legal decimation factor shrinks as the order grows, which keeps the internal word growth within a fixed budget. Any change to the configuration wipes the filter state, so the next output is computed only from samples taken after the change. In bypass, each sample appears unchanged at the output one cycle after it is accepted.

Top module: `cic_decim`

## Requirements
- R1: While reset is asserted and after its release with no accepted sample, outValid is 0 and outI and outQ are 0.
- R2: With order N and decimation R, each output equals the N-fold cascade of length-R moving sums of the scaled input, taken at every R-th accepted sample counted from the last clear. The I and Q lanes are filtered independently.
- R3: Exactly one outValid pulse occurs per R accepted samples. It comes one clock after the edge that accepts the R-th sample. Cycles with inValid low are ignored, whatever their data.
- R4: Order code 0 acts as 1, and codes 6 and 7 act as 5. A decimation value below 2 acts as 2. A decimation value above the order's limit acts as that limit, where the limit is 65536 for orders 1 and 2, 32768 for order 3, 2048 for order 4 and 512 for order 5.
- R5: Shift code s (6 bits) scales each input by 2^(s-45) before the integrators. Codes above 47 act as 47.
- R6: The filtered value is rounded half-up to an integer (add one half, then floor) and saturated to the signed OUT_W range.
- R7: With bypass set, every accepted sample appears unchanged on outI/outQ with outValid one clock after the accepting edge. No shift is applied in bypass.
- R8: A change in any configuration input clears all integrator, comb and counter state. The sample accepted in that cycle is discarded and produces no output.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| inValid | input | 1 | Input sample strobe |
| inI | input | IN_W | Signed in-phase sample |
| inQ | input | IN_W | Signed quadrature sample |
| cfgOrder | input | 3 | Filter order code |
| cfgDecim | input | 17 | Decimation factor R |
| cfgShift | input | 6 | Gain code, gain 2^(code-45) |
| cfgBypass | input | 1 | Pass samples through unfiltered |
| outValid | output | 1 | Output sample strobe |
| outI | output | OUT_W | Signed in-phase result |
| outQ | output | OUT_W | Signed quadrature result |

## Verification
A configuration change and an accepted sample can land in the same cycle. The sharpest case is when that sample is the R-th one, which would otherwise emit an output. The bench provokes this case by changing the decimation factor on the edge that accepts the fourth sample at R=4. It then expects no output pulse on the following cycle. It also expects every later output to match a model started from zero state, so both the discarded sample and the cleared history are judged.

// File: rtl/cic_pkg.sv
package cic_pkg;
  localparam int MAX_ORDER = 5;
  localparam int ORDER_W   = 3;
  localparam int DECIM_W   = 17;
  localparam int SHIFT_W   = 6;
  localparam int FRAC_W    = 45;   // deepest attenuation, 2^-45
  localparam int UP_MAX    = 2;    // largest gain, 2^2
  localparam int GROWTH_W  = 45;   // worst CIC bit growth over all legal settings
  localparam int SHIFT_MAX = FRAC_W + UP_MAX;

  typedef struct packed {
    logic               clr;
    logic               step;
    logic               dump;
    logic               load;
    logic               byp;
    logic [ORDER_W-1:0] order;
    logic [SHIFT_W-1:0] shift;
  } ctl_t;

  function automatic logic [DECIM_W-1:0] maxDecim(input logic [ORDER_W-1:0] ord);
    case (ord)
      3'd1, 3'd2: maxDecim = DECIM_W'(65536);
      3'd3:       maxDecim = DECIM_W'(32768);
      3'd4:       maxDecim = DECIM_W'(2048);
      default:    maxDecim = DECIM_W'(512);
    endcase
  endfunction
endpackage

// File: rtl/cic_ctrl.sv
module cic_ctrl
  import cic_pkg::*;
(
  input  logic               clk,
  input  logic               rstN,
  input  logic               inValid,
  input  logic [ORDER_W-1:0] cfgOrder,
  input  logic [DECIM_W-1:0] cfgDecim,
  input  logic [SHIFT_W-1:0] cfgShift,
  input  logic               cfgBypass,
  output ctl_t               ctl,
  output logic               outValid
);
  localparam int CFG_W = ORDER_W + DECIM_W + SHIFT_W + 1;

  logic [CFG_W-1:0]   cfgNow, cfgPrev;
  logic               changed;
  logic [ORDER_W-1:0] effOrder;
  logic [DECIM_W-1:0] effDecim, decimLim;
  logic [SHIFT_W-1:0] effShift;
  logic [DECIM_W-1:0] cnt;
  logic               stepEn, dumpEn, loadEn;

  assign cfgNow  = {cfgOrder, cfgDecim, cfgShift, cfgBypass};
  assign changed = (cfgNow != cfgPrev);

  always_comb begin
    if (cfgOrder == '0)                       effOrder = ORDER_W'(1);
    else if (cfgOrder > ORDER_W'(MAX_ORDER))  effOrder = ORDER_W'(MAX_ORDER);
    else                                      effOrder = cfgOrder;
    decimLim = maxDecim(effOrder);
    if (cfgDecim < DECIM_W'(2))               effDecim = DECIM_W'(2);
    else if (cfgDecim > decimLim)             effDecim = decimLim;
    else                                      effDecim = cfgDecim;
    effShift = (cfgShift > SHIFT_W'(SHIFT_MAX)) ? SHIFT_W'(SHIFT_MAX) : cfgShift;
  end

  assign stepEn = inValid && !cfgBypass && !changed;
  assign dumpEn = stepEn && (cnt == effDecim - DECIM_W'(1));
  assign loadEn = dumpEn || (inValid && cfgBypass && !changed);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cfgPrev  <= '0;
      cnt      <= '0;
      outValid <= 1'b0;
    end else begin
      cfgPrev  <= cfgNow;
      outValid <= loadEn;
      if (changed)     cnt <= '0;
      else if (dumpEn) cnt <= '0;
      else if (stepEn) cnt <= cnt + DECIM_W'(1);
    end
  end

  assign ctl = '{clr: changed, step: stepEn, dump: dumpEn, load: loadEn,
                 byp: cfgBypass, order: effOrder, shift: effShift};

  // R3
  cnt_bound_chk: assert property (@(posedge clk) disable iff (!rstN)
    !changed |-> (cnt < effDecim));
  // R3
  out_needs_in_chk: assert property (@(posedge clk) disable iff (!rstN)
    outValid |-> $past(inValid));
  // R8
  clr_silence_chk: assert property (@(posedge clk) disable iff (!rstN)
    changed |=> !outValid);
  // R7
  byp_pass_chk: assert property (@(posedge clk) disable iff (!rstN)
    (cfgBypass && inValid && !changed) |=> outValid);
endmodule

// File: rtl/cic_lane.sv
module cic_lane
  import cic_pkg::*;
#(
  parameter int IN_W  = 16,
  parameter int OUT_W = 16,
  parameter int ACC_W = IN_W + FRAC_W + UP_MAX + GROWTH_W
) (
  input  logic                    clk,
  input  logic                    rstN,
  input  ctl_t                    ctl,
  input  logic signed [IN_W-1:0]  sampleIn,
  output logic signed [OUT_W-1:0] sampleOut
);
  localparam logic signed [ACC_W-1:0] HALF =
    {{(ACC_W-FRAC_W){1'b0}}, 1'b1, {(FRAC_W-1){1'b0}}};
  localparam logic signed [ACC_W-1:0] OUT_MAX =
    {{(ACC_W-OUT_W+1){1'b0}}, {(OUT_W-1){1'b1}}};
  localparam logic signed [ACC_W-1:0] OUT_MIN =
    {{(ACC_W-OUT_W+1){1'b1}}, {(OUT_W-1){1'b0}}};

  logic signed [ACC_W-1:0] ext, scaled;
  logic [MAX_ORDER:0][ACC_W-1:0] intChain, combChain;
  logic signed [ACC_W-1:0] resVal, rnd, whole;
  logic signed [OUT_W-1:0] satVal;

  assign ext       = {{(ACC_W-IN_W){sampleIn[IN_W-1]}}, sampleIn};
  assign scaled    = ext <<< ctl.shift;
  assign intChain[0]  = scaled;
  assign combChain[0] = intChain[MAX_ORDER];

  for (genvar k = 0; k < MAX_ORDER; k++) begin : g_stage
    logic             stageOn;
    logic [ACC_W-1:0] intAcc, combDly;
    assign stageOn = (ORDER_W'(k) < ctl.order);
    // unused stages are identity so one datapath serves every order
    assign intChain[k+1]  = stageOn ? intAcc + intChain[k]       : intChain[k];
    assign combChain[k+1] = stageOn ? combChain[k] - combDly     : combChain[k];

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        intAcc  <= '0;
        combDly <= '0;
      end else if (ctl.clr) begin
        intAcc  <= '0;
        combDly <= '0;
      end else begin
        if (ctl.step && stageOn) intAcc  <= intChain[k+1];
        if (ctl.dump && stageOn) combDly <= combChain[k];
      end
    end

    // R8
    int_clear_chk: assert property (@(posedge clk) disable iff (!rstN)
      ctl.clr |=> (intAcc == '0 && combDly == '0));
  end

  assign resVal = ctl.byp ? (ext <<< FRAC_W) : $signed(combChain[MAX_ORDER]);
  assign rnd    = resVal + HALF;
  assign whole  = rnd >>> FRAC_W;

  always_comb begin
    if (whole > OUT_MAX)      satVal = OUT_MAX[OUT_W-1:0];
    else if (whole < OUT_MIN) satVal = OUT_MIN[OUT_W-1:0];
    else                      satVal = whole[OUT_W-1:0];
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)         sampleOut <= '0;
    else if (ctl.load) sampleOut <= satVal;
  end
endmodule

// File: rtl/cic_decim.sv
module cic_decim
  import cic_pkg::*;
#(
  parameter int IN_W  = 16,
  parameter int OUT_W = 16
) (
  input  logic                    clk,
  input  logic                    rstN,
  input  logic                    inValid,
  input  logic signed [IN_W-1:0]  inI,
  input  logic signed [IN_W-1:0]  inQ,
  input  logic [ORDER_W-1:0]      cfgOrder,
  input  logic [DECIM_W-1:0]      cfgDecim,
  input  logic [SHIFT_W-1:0]      cfgShift,
  input  logic                    cfgBypass,
  output logic                    outValid,
  output logic signed [OUT_W-1:0] outI,
  output logic signed [OUT_W-1:0] outQ
);
  localparam int ACC_W = IN_W + FRAC_W + UP_MAX + GROWTH_W;

  ctl_t ctl;

  cic_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .inValid(inValid),
    .cfgOrder(cfgOrder), .cfgDecim(cfgDecim), .cfgShift(cfgShift),
    .cfgBypass(cfgBypass), .ctl(ctl), .outValid(outValid)
  );

  cic_lane #(.IN_W(IN_W), .OUT_W(OUT_W), .ACC_W(ACC_W)) u_laneI (
    .clk(clk), .rstN(rstN), .ctl(ctl), .sampleIn(inI), .sampleOut(outI)
  );

  cic_lane #(.IN_W(IN_W), .OUT_W(OUT_W), .ACC_W(ACC_W)) u_laneQ (
    .clk(clk), .rstN(rstN), .ctl(ctl), .sampleIn(inQ), .sampleOut(outQ)
  );
endmodule

// File: tb/sim_cic_decim.sv
`timescale 1ns/1ps
module sim_cic_decim;
  localparam int RING = 512;

  logic clk = 1'b0;
  logic rstN;
  logic inValid;
  logic signed [15:0] inI, inQ;
  logic [2:0]  cfgOrder;
  logic [16:0] cfgDecim;
  logic [5:0]  cfgShift;
  logic        cfgBypass;
  logic        outValid;
  logic signed [15:0] outI, outQ;

  always #2 clk = ~clk;

  cic_decim u0 (
    .clk(clk), .rstN(rstN), .inValid(inValid), .inI(inI), .inQ(inQ),
    .cfgOrder(cfgOrder), .cfgDecim(cfgDecim), .cfgShift(cfgShift),
    .cfgBypass(cfgBypass), .outValid(outValid), .outI(outI), .outQ(outQ)
  );

  int checks = 0;
  int fails  = 0;
  bit pend = 0;
  bit valOn = 1;
  logic signed [15:0] expI, expQ;
  int gotCount;
  string validReq = "R3";
  string valReq   = "R2";
  logic signed [127:0] ringI [0:5][0:RING-1];
  logic signed [127:0] ringQ [0:5][0:RING-1];

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  function automatic int effOrd(input int o);
    return (o == 0) ? 1 : ((o > 5) ? 5 : o);
  endfunction
  function automatic int maxR(input int o);
    return (o <= 2) ? 65536 : ((o == 3) ? 32768 : ((o == 4) ? 2048 : 512));
  endfunction
  function automatic int effDec(input int o, input int d);
    return (d < 2) ? 2 : ((d > maxR(o)) ? maxR(o) : d);
  endfunction
  function automatic int effSh(input int s);
    return (s > 47) ? 47 : s;
  endfunction

  function automatic logic signed [15:0] finishVal(input logic signed [127:0] y);
    logic signed [127:0] r;
    r = (y + (128'sd1 <<< 44)) >>> 45;
    if (r > 128'sd32767)  return 16'sh7fff;
    if (r < -128'sd32768) return 16'sh8000;
    return r[15:0];
  endfunction

  function automatic logic signed [127:0] rd(input int lane, input int j, input int idx);
    return (lane == 0) ? ringI[j][idx] : ringQ[j][idx];
  endfunction

  task automatic wr(input int lane, input int j, input int idx, input logic signed [127:0] v);
    if (lane == 0) ringI[j][idx] = v;
    else           ringQ[j][idx] = v;
  endtask

  // cascade of moving sums over the accepted, scaled samples
  task automatic modelStep(input int lane, input logic signed [15:0] x, input int n,
                           input int eO, input int eR, input int eS,
                           output logic signed [127:0] y);
    logic signed [127:0] v [0:5];
    logic signed [127:0] xe, old, prev;
    xe = x;
    v[0] = xe <<< eS;
    for (int j = 1; j <= eO; j++) begin
      old  = (n >= eR) ? rd(lane, j-1, (n-eR) % RING) : 128'sd0;
      prev = (n > 0)   ? rd(lane, j, (n-1) % RING)    : 128'sd0;
      v[j] = prev + v[j-1] - old;
    end
    for (int j = 0; j <= eO; j++) wr(lane, j, n % RING, v[j]);
    y = v[eO];
  endtask

  task automatic step(input bit v, input logic signed [15:0] i, input logic signed [15:0] q);
    @(negedge clk);
    chk(outValid == pend, validReq, "outValid timing", outValid, pend);
    if (pend && outValid && valOn) begin
      chk(outI == expI, valReq, "outI", outI, expI);
      chk(outQ == expQ, valReq, "outQ", outQ, expQ);
    end
    if (outValid) gotCount++;
    pend = 0;
    inValid = v; inI = i; inQ = q;
  endtask

  task automatic runCic(input int o, input int d, input int s, input bit b,
                        input int n, input int amp, input bit withVals, input string req);
    int eO, eR, eS, m;
    logic signed [127:0] yI, yQ;
    eO = effOrd(o); eR = effDec(eO, d); eS = effSh(s); m = 0;
    step(0, 0, 0);
    cfgOrder = 3'(o); cfgDecim = 17'(d); cfgShift = 6'(s); cfgBypass = b;
    step(0, 0, 0);
    step(0, 0, 0);
    gotCount = 0;
    validReq = b ? "R7" : "R3";
    valReq = req;
    valOn = withVals;
    while (m < n) begin
      bit v;
      logic signed [15:0] xi, xq;
      v  = ($urandom_range(0, 3) != 0);
      xi = 16'($urandom_range(0, 2*amp) - amp);
      xq = 16'($urandom_range(0, 2*amp) - amp);
      step(v, xi, xq);
      if (v) begin
        if (b) begin
          pend = 1; expI = xi; expQ = xq;
        end else begin
          if (withVals) begin
            modelStep(0, xi, m, eO, eR, eS, yI);
            modelStep(1, xq, m, eO, eR, eS, yQ);
            expI = finishVal(yI);
            expQ = finishVal(yQ);
          end
          if ((m + 1) % eR == 0) pend = 1;
        end
        m++;
      end
    end
    step(0, 0, 0);
    chk(gotCount == (b ? n : n / eR), b ? "R7" : "R3", "output count",
        gotCount, b ? n : n / eR);
    valOn = 1;
  endtask

  initial begin
    void'($urandom(32'd20240611));
    rstN = 0; inValid = 0; inI = 0; inQ = 0;
    cfgOrder = 0; cfgDecim = 0; cfgShift = 0; cfgBypass = 0;
    repeat (3) @(negedge clk);
    chk(outValid == 0, "R1", "outValid in reset", outValid, 0);
    chk(outI == 0 && outQ == 0, "R1", "outputs in reset", outI, 0);
    rstN = 1;
    @(negedge clk);
    chk(outValid == 0, "R1", "outValid after reset", outValid, 0);
    chk(outQ == 0, "R1", "outQ after reset", outQ, 0);

    runCic(1, 2, 45, 0, 40, 20000, 1, "R2");
    runCic(2, 7, 39, 0, 100, 32767, 1, "R2");
    runCic(3, 16, 33, 0, 200, 30000, 1, "R5");
    runCic(5, 512, 0, 0, 1100, 32767, 1, "R2");
    runCic(4, 4000, 1, 0, 4200, 1000, 0, "R4");
    runCic(0, 1, 63, 0, 80, 6000, 1, "R6");
    runCic(7, 3, 37, 0, 60, 30000, 1, "R4");
    runCic(5, 1000, 0, 0, 600, 30000, 1, "R4");
    runCic(2, 9, 40, 1, 50, 32767, 1, "R7");

    // R8: change on the same edge as the sample that would end a block
    step(0, 0, 0);
    cfgOrder = 1; cfgDecim = 4; cfgShift = 45; cfgBypass = 0;
    step(0, 0, 0); step(0, 0, 0);
    step(1, 100, -100); step(1, 200, 5); step(1, 300, 7); step(1, 400, 9);
    cfgDecim = 17'd5;
    step(0, 0, 0);
    chk(outValid == 0, "R8", "no output from dropped sample", outValid, 0);
    runCic(1, 5, 45, 0, 30, 1000, 1, "R8");

    for (int t = 0; t < 4; t++) begin
      runCic($urandom_range(1, 5), $urandom_range(2, 20), $urandom_range(25, 47),
             0, 80, 32767, 1, "R2");
    end

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule